// File: doc/BRIEF.md
# Generator Slot Allocator

This block assigns waveform requests from many output channels to a small pool of shared generator slots. A request names a channel, a period in ticks and a duty value on a 0..255 scale, where 255 means always on. Each slot holds one period and duty pair and a count of the channels attached to it. The allocator answers each request with one of three results: the slot index granted plus a flag saying whether that slot has to be (re)programmed, a report that the channel is now switched off, or a refusal.

A request with duty 0 needs no generator. The allocator only detaches the channel from the slot it held. For any other duty it walks the slots one per cycle, in ascending index order. The first choice is a slot that already produces what was asked for. The second is an empty slot. The last is the nearest used slot that does not overshoot the request. When a request is granted, the slot the channel held before is released first and then the chosen slot is claimed. A table inside the block records which slot each channel holds.

Top module: `gen_slot_alloc`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, every slot count is zero and no channel holds a slot.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the response. `rsp_valid` is a one-cycle pulse that appears NSLOT+1 edges after the accepting edge.
- R3: If a used slot (count above zero) has exactly the requested period and duty, the lowest such index is granted. This result has priority over every other outcome.
- R4: A request with duty 255 takes the lowest-index used slot whose duty is 255, whatever that slot's period is.
- R5: If no slot matches under R3 or R4 and some slot is free, the highest-index free slot is granted, `rsp_program` is 1, and the slot stores the requested period and duty.
- R6: If no slot matches and none is free, the used slots are scanned from index 0 upward, skipping any whose period exceeds the request. The on-time of a slot is its period × duty, and the on-time of the request is computed the same way. A slot replaces the current best when its period is at least the best period so far, its on-time does not exceed the requested on-time, and its on-time is strictly greater than the best on-time so far, which starts at 0. The final best slot is granted.
- R7: If nothing can be granted, the response has `rsp_ok`=0 and `rsp_slot`=0. No slot count and no channel assignment changes.
- R8: On a grant, the slot the channel held before (if it held one) is decremented before the new slot is counted. The channel then holds the new slot.
- R9: A request with duty 0 responds `rsp_ok`=1 and `rsp_off`=1, with `rsp_program`=0 and `rsp_slot`=0. It releases the slot the channel held, if any.
- R10: `rsp_program` is 1 exactly when the granted slot's count is zero after the release in R8. This includes the case where the channel re-requests its own slot as the only user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Allocator idle and able to accept a request |
| req_chan | input | clog2(NCHAN) | Channel issuing the request |
| req_period | input | PW | Requested period in ticks |
| req_duty | input | DW | Requested duty; 0 = off, all ones = always on |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Request granted (or channel switched off) |
| rsp_off | output | 1 | Channel was switched off (duty 0) |
| rsp_program | output | 1 | Granted slot must be loaded with the new period and duty |
| rsp_slot | output | clog2(NSLOT) | Granted slot index |

## Verification
The assertions assume two things about the inputs. First, `req_chan` is always below NCHAN. Second, the requester never changes the request fields while a request is in flight; the allocator captures them at acceptance, so this follows from the handshake. The stimulus issues one request at a time, waits for each response before sending the next, and uses only in-range channels. A reference model in the bench tracks slot counts and channel ownership. Its sequence walks through free allocation, exact reuse, full-duty sharing, filling the pool, refusals and nearest-fit grants.

// File: rtl/gsa_pkg.sv
package gsa_pkg;

  // Controller phases of one allocation
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_COMMIT = 2'd2
  } gsa_state_e;

endpackage

// File: rtl/gsa_slot_bank.sv
module gsa_slot_bank #(
  parameter int NSLOT = 8,
  parameter int PW    = 8,
  parameter int DW    = 8,
  parameter int CNTW  = 6,
  localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic            clk,
  input  logic            rst,
  // scan read port
  input  logic [IW-1:0]   rd_idx,
  output logic            rd_used,
  output logic [PW-1:0]   rd_per,
  output logic [DW-1:0]   rd_duty,
  // commit port
  input  logic            dec_en,
  input  logic [IW-1:0]   dec_idx,
  input  logic            inc_en,
  input  logic [IW-1:0]   inc_idx,
  input  logic [PW-1:0]   inc_per,
  input  logic [DW-1:0]   inc_duty,
  output logic            prog_o
);

  logic [CNTW-1:0] cnt   [NSLOT];
  logic [PW-1:0]   per   [NSLOT];
  logic [DW-1:0]   duty  [NSLOT];
  logic [CNTW-1:0] post_release;
  logic            same_slot;

  assign rd_used = (cnt[rd_idx] != '0);
  assign rd_per  = per[rd_idx];
  assign rd_duty = duty[rd_idx];

  // count of the target slot once the channel's old slot is let go
  assign same_slot    = dec_en && (dec_idx == inc_idx);
  assign post_release = cnt[inc_idx] - CNTW'(same_slot);
  assign prog_o       = (post_release == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSLOT; s++) begin
        cnt[s]  <= '0;
        per[s]  <= '0;
        duty[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        cnt[s] <= cnt[s]
                  - CNTW'(dec_en && (dec_idx == IW'(s)))
                  + CNTW'(inc_en && (inc_idx == IW'(s)));
        if (inc_en && (inc_idx == IW'(s)) && prog_o) begin
          per[s]  <= inc_per;
          duty[s] <= inc_duty;
        end
      end
    end
  end

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec_en |-> (cnt[dec_idx] != '0));

  // R5
  load_free_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_en && prog_o) |=> (cnt[$past(inc_idx)] == CNTW'(1)));

endmodule

// File: rtl/gsa_scan.sv
module gsa_scan #(
  parameter int NSLOT = 8,
  parameter int PW    = 8,
  parameter int DW    = 8,
  localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int TW   = PW + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          step,
  input  logic [IW-1:0] idx,
  input  logic          slot_used,
  input  logic [PW-1:0] slot_per,
  input  logic [DW-1:0] slot_duty,
  input  logic [PW-1:0] req_per,
  input  logic [DW-1:0] req_duty,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output logic          free_found,
  output logic [IW-1:0] free_idx,
  output logic          best_found,
  output logic [IW-1:0] best_idx
);

  localparam logic [DW-1:0] FULL = '1;

  logic [TW-1:0] cand_t, req_t, best_t;
  logic [PW-1:0] best_p;
  logic          exact, full_share, match_now, fits;

  assign cand_t     = TW'(slot_per) * TW'(slot_duty);
  assign req_t      = TW'(req_per) * TW'(req_duty);
  assign exact      = (slot_per == req_per) && (slot_duty == req_duty);
  assign full_share = (req_duty == FULL) && (slot_duty == FULL);
  assign match_now  = slot_used && (exact || full_share);
  assign fits       = slot_used && !match_now
                      && (slot_per <= req_per) && (slot_per >= best_p)
                      && (cand_t <= req_t) && (cand_t > best_t);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      hit        <= 1'b0;
      hit_idx    <= '0;
      free_found <= 1'b0;
      free_idx   <= '0;
      best_found <= 1'b0;
      best_idx   <= '0;
      best_t     <= '0;
      best_p     <= '0;
    end else if (step) begin
      if (!slot_used) begin
        free_found <= 1'b1;
        free_idx   <= idx;
      end
      if (match_now && !hit) begin
        hit     <= 1'b1;
        hit_idx <= idx;
      end
      if (fits) begin
        best_found <= 1'b1;
        best_idx   <= idx;
        best_t     <= cand_t;
        best_p     <= slot_per;
      end
    end
  end

  // R3
  first_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (step && hit) |=> (hit && $stable(hit_idx)));

  // R6
  best_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (step && best_found && !start) |=> (best_found && (best_t >= $past(best_t))));

endmodule

// File: rtl/gen_slot_alloc.sv
module gen_slot_alloc
  import gsa_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int NCHAN = 33,
  parameter int PW    = 8,
  parameter int DW    = 8,
  localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW   = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_chan,
  input  logic [PW-1:0] req_period,
  input  logic [DW-1:0] req_duty,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic          rsp_off,
  output logic          rsp_program,
  output logic [IW-1:0] rsp_slot
);

  localparam int CNTW = $clog2(NCHAN + 1);

  gsa_state_e    st;
  logic [IW-1:0] idx;
  logic [CW-1:0] chan_q;
  logic [PW-1:0] per_q;
  logic [DW-1:0] duty_q;
  logic          prev_valid;
  logic [IW-1:0] prev_slot;
  logic [NCHAN-1:0] chan_live;
  logic [IW-1:0] slot_tab [NCHAN];

  logic          accept, in_scan, in_commit;
  logic          is_off, found, grant_ok, inc_en, dec_en;
  logic [IW-1:0] sel_idx;

  logic          rd_used;
  logic [PW-1:0] rd_per;
  logic [DW-1:0] rd_duty;
  logic          bank_prog;
  logic          hit, free_found, best_found;
  logic [IW-1:0] hit_idx, free_idx, best_idx;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign in_scan   = (st == ST_SCAN);
  assign in_commit = (st == ST_COMMIT);

  // channel -> slot table, synchronous read at acceptance
  always_ff @(posedge clk) begin
    if (accept)
      prev_slot <= slot_tab[req_chan];
    if (inc_en)
      slot_tab[chan_q] <= sel_idx;
  end

  // grant selection: match, then free, then nearest fit
  always_comb begin
    is_off  = (duty_q == '0);
    found   = 1'b0;
    sel_idx = '0;
    if (hit) begin
      found   = 1'b1;
      sel_idx = hit_idx;
    end else if (free_found) begin
      found   = 1'b1;
      sel_idx = free_idx;
    end else if (best_found) begin
      found   = 1'b1;
      sel_idx = best_idx;
    end
    grant_ok = is_off || found;
  end

  assign inc_en = in_commit && found && !is_off;
  assign dec_en = in_commit && grant_ok && prev_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      idx         <= '0;
      chan_q      <= '0;
      per_q       <= '0;
      duty_q      <= '0;
      prev_valid  <= 1'b0;
      chan_live   <= '0;
      rsp_valid   <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_off     <= 1'b0;
      rsp_program <= 1'b0;
      rsp_slot    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            st         <= ST_SCAN;
            idx        <= '0;
            chan_q     <= req_chan;
            per_q      <= req_period;
            duty_q     <= req_duty;
            prev_valid <= chan_live[req_chan];
          end
        end
        ST_SCAN: begin
          if (idx == IW'(NSLOT - 1))
            st <= ST_COMMIT;
          else
            idx <= idx + 1'b1;
        end
        ST_COMMIT: begin
          st          <= ST_IDLE;
          rsp_valid   <= 1'b1;
          rsp_ok      <= grant_ok;
          rsp_off     <= is_off;
          rsp_program <= inc_en && bank_prog;
          rsp_slot    <= inc_en ? sel_idx : '0;
          if (grant_ok)
            chan_live[chan_q] <= !is_off;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  gsa_slot_bank #(
    .NSLOT (NSLOT),
    .PW    (PW),
    .DW    (DW),
    .CNTW  (CNTW)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (idx),
    .rd_used  (rd_used),
    .rd_per   (rd_per),
    .rd_duty  (rd_duty),
    .dec_en   (dec_en),
    .dec_idx  (prev_slot),
    .inc_en   (inc_en),
    .inc_idx  (sel_idx),
    .inc_per  (per_q),
    .inc_duty (duty_q),
    .prog_o   (bank_prog)
  );

  gsa_scan #(
    .NSLOT (NSLOT),
    .PW    (PW),
    .DW    (DW)
  ) u_scan (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .step       (in_scan),
    .idx        (idx),
    .slot_used  (rd_used),
    .slot_per   (rd_per),
    .slot_duty  (rd_duty),
    .req_per    (per_q),
    .req_duty   (duty_q),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .free_found (free_found),
    .free_idx   (free_idx),
    .best_found (best_found),
    .best_idx   (best_idx)
  );

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R10
  prog_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_program) |-> (rsp_ok && !rsp_off));

  // R9
  off_noslot_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_off) |-> (rsp_ok && !rsp_program && (rsp_slot == '0)));

  // R7
  refuse_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ok) |-> (!rsp_program && !rsp_off && (rsp_slot == '0)));

  // R2 (input assumption: channel in range)
  chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (int'(req_chan) < NCHAN));

endmodule

// File: tb/sim_gen_slot_alloc.sv
module sim_gen_slot_alloc;

  localparam int NSLOT = 8;
  localparam int NCHAN = 33;
  localparam int IW    = 3;
  localparam int CW    = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [CW-1:0] req_chan = '0;
  logic [7:0]    req_period = '0;
  logic [7:0]    req_duty = '0;
  logic          rsp_valid, rsp_ok, rsp_off, rsp_program;
  logic [IW-1:0] rsp_slot;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gen_slot_alloc #(.NSLOT(NSLOT), .NCHAN(NCHAN)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_period(req_period), .req_duty(req_duty),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_off(rsp_off),
    .rsp_program(rsp_program), .rsp_slot(rsp_slot)
  );

  // reference model state
  int m_cnt  [NSLOT];
  int m_per  [NSLOT];
  int m_duty [NSLOT];
  bit m_live [NCHAN];
  int m_slot [NCHAN];

  typedef struct {
    bit    ok;
    bit    off;
    bit    prog;
    int    slot;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(bit cond, string tag, string what, int act, int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: predict from the requirements, queue, then issue the request
  task automatic request(int ch, int p, int d, string tag);
    exp_t e;
    int hit = -1, fre = -1, best = -1, bp = 0, bt = 0, sel, lat;
    bit  busy_bad = 1'b0;
    e.tag = tag; e.ok = 1'b0; e.off = 1'b0; e.prog = 1'b0; e.slot = 0;
    if (d == 0) begin
      e.ok = 1'b1; e.off = 1'b1;
      if (m_live[ch]) m_cnt[m_slot[ch]]--;
      m_live[ch] = 1'b0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (m_cnt[i] == 0) fre = i;
        else if (hit < 0 && ((m_per[i] == p && m_duty[i] == d) ||
                             (d == 255 && m_duty[i] == 255))) hit = i;
        else if (m_per[i] <= p && m_per[i] >= bp &&
                 m_per[i] * m_duty[i] <= p * d && m_per[i] * m_duty[i] > bt) begin
          best = i; bp = m_per[i]; bt = m_per[i] * m_duty[i];
        end
      end
      sel = (hit >= 0) ? hit : (fre >= 0) ? fre : best;
      if (sel >= 0) begin
        e.ok = 1'b1; e.slot = sel;
        if (m_live[ch]) m_cnt[m_slot[ch]]--;
        e.prog = (m_cnt[sel] == 0);
        if (e.prog) begin m_per[sel] = p; m_duty[sel] = d; end
        m_cnt[sel]++;
        m_live[ch] = 1'b1;
        m_slot[ch] = sel;
      end
    end
    sb.push_back(e);

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_chan = CW'(ch); req_period = 8'(p); req_duty = 8'(d);
    lat = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (!rsp_valid && req_ready) busy_bad = 1'b1;
    end while (!rsp_valid && lat < 40);
    // R2: response NSLOT+1 edges after acceptance, ready low meanwhile
    check(lat == NSLOT + 2, "R2", "latency", lat, NSLOT + 2);
    check(!busy_bad, "R2", "ready low while busy", busy_bad, 0);
  endtask

  // monitor: compare each response with the queued prediction
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_ok == e.ok, e.tag, "ok", rsp_ok, e.ok);
        check(rsp_off == e.off, e.tag, "off", rsp_off, e.off);
        check(rsp_program == e.prog, e.tag, "program", rsp_program, e.prog);
        check(int'(rsp_slot) == e.slot, e.tag, "slot", rsp_slot, e.slot);
      end
    end
  end

  initial begin
    for (int i = 0; i < NSLOT; i++) begin m_cnt[i] = 0; m_per[i] = 0; m_duty[i] = 0; end
    for (int c = 0; c < NCHAN; c++) begin m_live[c] = 1'b0; m_slot[c] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);

    request(0, 10, 100, "R5");       // free slot 7, program
    request(1, 10, 100, "R3");       // exact reuse
    request(2, 20, 255, "R5");       // next free slot
    request(3, 50, 255, "R4");       // full duty shares across periods
    request(4, 0, 0, "R9");          // off, channel held nothing
    request(0, 0, 0, "R9");          // off, releases one user
    request(1, 12, 80, "R8");        // move: old slot drops to zero
    request(1, 12, 80, "R10");       // own slot as sole user: reprogram
    request(5, 40, 100, "R5");
    request(6, 30, 200, "R5");
    request(7, 60, 50, "R5");
    request(8, 5, 10, "R5");
    request(9, 100, 128, "R5");
    request(10, 70, 90, "R5");       // pool now full
    request(12, 3, 100, "R7");       // nothing fits: refusal
    request(12, 50, 150, "R6");      // nearest fit
    request(5, 3, 100, "R7");        // refusal keeps channel's slot
    request(5, 0, 0, "R8");          // release frees that slot
    request(13, 9, 9, "R7");         // freed slot reused, program
    request(20, 200, 255, "R4");     // full duty share again
    request(32, 250, 1, "R6");       // tight on-time fit
    request(9, 100, 100, "R10");     // leaves own slot, no free slot
    request(9, 100, 128, "R3");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2", "pending responses", sb.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule